// File: doc/BRIEF.md
# Manchester Line Transmitter with Preamble

This block turns parallel data words into a Manchester-coded serial line. A word is offered on a valid/ready handshake. Once accepted, the block can send a short preamble of 1 to 15 bit periods, chosen from four fixed patterns. The data bits follow at once, least significant bit first. Every bit, preamble or data, fills one bit period, and the line always changes level at mid-bit. A configuration input picks the coding polarity. The preamble follows the same polarity as the data.

Timing comes from an external rate generator. That generator supplies `half_tick`, a one-cycle strobe at each half-bit boundary, so it runs at twice the bit rate. Framing, parity and rate generation belong to the surrounding logic. The polarity, preamble length and pattern inputs are sampled when a word is accepted. They are held inside the block for the whole frame.

The sequencer has four states:
- `S_IDLE` holds the line high with ready asserted. It moves to `S_ARM` on accept.
- `S_ARM` waits for the first strobe. That strobe moves it to `S_PRE` if the preamble length is nonzero, or to `S_DATA` if it is zero.
- `S_PRE` moves to `S_DATA` after the second half of the last preamble bit.
- `S_DATA` moves back to `S_IDLE` on the strobe that follows the second half of the last data bit.

Top module: `manchester_tx`

## Requirements
- R1: After reset the line output is 1, busy is 0 and in_ready is 1.
- R2: A word is accepted on a clock edge where in_valid and in_ready are both 1. From the next cycle busy is 1, in_ready is 0 and the line is still 1. in_valid while busy is ignored: it alters neither the frame in progress nor the idle state that follows it.
- R3: With polarity 0, a bit value b is sent as level b in the first half of its bit period and as ~b in the second half. So a zero is a low-to-high transition at mid-bit and a one is a high-to-low transition.
- R4: With polarity 1, bit b is sent as ~b in the first half and b in the second half.
- R5: All DATA_W data bits are sent least significant bit first.
- R6: A preamble length of 0 sends no preamble. A length N from 1 to 15 sends exactly N preamble bits directly before the data, with no gap.
- R7: The pattern code gives the preamble bit values before polarity is applied: 2'b00 all ones, 2'b01 all zeros, 2'b10 alternating starting with 0, 2'b11 alternating starting with 1. Preamble bits are then coded with the selected polarity, as data bits are.
- R8: The line changes only in the cycle after a half_tick strobe. The first strobe after accept shows the first half of the first bit. The strobe after the last half returns the line to 1, and busy goes to 0 and in_ready to 1 at that same edge.
- R9: Changes to polarity, preamble length or pattern after a word has been accepted have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | DATA_W | Word to send |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can accept a word (idle) |
| half_tick | input | 1 | One-cycle strobe at each half-bit boundary |
| cfg_inv | input | 1 | Coding polarity select |
| cfg_pre_len | input | 4 | Preamble length in bit periods, 0 disables |
| cfg_pre_pat | input | 2 | Preamble pattern code |
| line_out | output | 1 | Manchester serial line |
| busy | output | 1 | Frame in progress |

## Verification
The bench issues every strobe itself, so it always knows the edge at which the registered line must take its next half-bit value. The line is due one edge after a strobe. The bench drops the strobe at the next falling edge, holds it low for two more cycles, and then compares the line with the half value it computed. That comparison also confirms that nothing moved between strobes. Busy and in_ready are due one edge after the accept edge, where the line must still be high. On the final strobe, busy must fall and the line must return high on that same edge. Further idle cycles then confirm that ignored in_valid pulses started nothing.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    localparam int PRE_LEN_W = 4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_PRE  = 2'd2,
        S_DATA = 2'd3
    } mtx_state_e;

    typedef enum logic [1:0] {
        PAT_ONES  = 2'b00,
        PAT_ZEROS = 2'b01,
        PAT_ZO    = 2'b10,
        PAT_OZ    = 2'b11
    } mtx_pat_e;

    typedef struct packed {
        logic                 inv;
        logic [PRE_LEN_W-1:0] len;
        mtx_pat_e             pat;
    } mtx_cfg_t;

endpackage

// File: rtl/mtx_pre_gen.sv
module mtx_pre_gen
    import mtx_pkg::*;
#(
    parameter int IDX_W = PRE_LEN_W
) (
    input  mtx_pat_e           pat,
    input  logic [IDX_W-1:0]   idx,
    output logic               bit_o
);

    always_comb begin
        unique case (pat)
            PAT_ONES:  bit_o = 1'b1;
            PAT_ZEROS: bit_o = 1'b0;
            PAT_ZO:    bit_o = idx[0];
            PAT_OZ:    bit_o = ~idx[0];
        endcase
    end

endmodule

// File: rtl/mtx_shift.sv
module mtx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              shift,
    output logic              cur_bit,
    output logic              next_bit
);

    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= din;
        end else if (shift) begin
            sh_q <= {1'b0, sh_q[DATA_W-1:1]};
        end
    end

    assign cur_bit  = sh_q[0];
    assign next_bit = sh_q[1];

endmodule

// File: rtl/mtx_seq.sv
module mtx_seq
    import mtx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BW    = $clog2(DATA_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 half_tick,
    input  mtx_cfg_t             cfg_in,
    input  logic                 pre_bit,
    input  logic                 data_cur,
    input  logic                 data_next,
    output logic                 load,
    output logic                 shift,
    output logic [PRE_LEN_W-1:0] pre_idx_next,
    output mtx_pat_e             pat_q,
    output logic                 line_q,
    output logic                 busy,
    output logic                 ready
);

    localparam logic [BW-1:0]        LAST_BIT = BW'(DATA_W - 1);
    localparam logic [PRE_LEN_W-1:0] ONE_L    = PRE_LEN_W'(1);

    mtx_state_e           state_q, state_n;
    mtx_cfg_t             cfg_q;
    logic                 half_q, half_n;
    logic [PRE_LEN_W-1:0] pidx_q, pidx_n;
    logic [BW-1:0]        bidx_q, bidx_n;
    logic                 line_n;

    assign load  = in_valid && (state_q == S_IDLE);
    assign ready = (state_q == S_IDLE);
    assign busy  = (state_q != S_IDLE);
    assign pat_q = cfg_q.pat;
    assign pre_idx_next = pidx_n;

    // next-state and next line value
    always_comb begin
        state_n = state_q;
        half_n  = half_q;
        pidx_n  = pidx_q;
        bidx_n  = bidx_q;
        shift   = 1'b0;
        line_n  = line_q;
        unique case (state_q)
            S_IDLE: begin
                line_n = 1'b1;
                if (load) begin
                    state_n = S_ARM;
                    half_n  = 1'b0;
                    pidx_n  = '0;
                    bidx_n  = '0;
                end
            end
            S_ARM: begin
                if (half_tick) begin
                    half_n = 1'b0;
                    if (cfg_q.len != '0) begin
                        state_n = S_PRE;
                        line_n  = pre_bit ^ cfg_q.inv;
                    end else begin
                        state_n = S_DATA;
                        line_n  = data_cur ^ cfg_q.inv;
                    end
                end
            end
            S_PRE: begin
                if (half_tick) begin
                    if (!half_q) begin
                        half_n = 1'b1;
                        line_n = ~line_q;
                    end else begin
                        half_n = 1'b0;
                        if (pidx_q == cfg_q.len - ONE_L) begin
                            state_n = S_DATA;
                            line_n  = data_cur ^ cfg_q.inv;
                        end else begin
                            pidx_n = pidx_q + ONE_L;
                            line_n = pre_bit ^ cfg_q.inv;
                        end
                    end
                end
            end
            S_DATA: begin
                if (half_tick) begin
                    if (!half_q) begin
                        half_n = 1'b1;
                        line_n = ~line_q;
                    end else begin
                        half_n = 1'b0;
                        if (bidx_q == LAST_BIT) begin
                            state_n = S_IDLE;
                            line_n  = 1'b1;
                        end else begin
                            bidx_n = bidx_q + BW'(1);
                            shift  = 1'b1;
                            line_n = data_next ^ cfg_q.inv;
                        end
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            half_q  <= 1'b0;
            pidx_q  <= '0;
            bidx_q  <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_n;
            half_q  <= half_n;
            pidx_q  <= pidx_n;
            bidx_q  <= bidx_n;
            if (load) begin
                cfg_q <= cfg_in;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else begin
            line_q <= line_n;
        end
    end

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
    import mtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 half_tick,
    input  logic                 cfg_inv,
    input  logic [PRE_LEN_W-1:0] cfg_pre_len,
    input  logic [1:0]           cfg_pre_pat,
    output logic                 line_out,
    output logic                 busy
);

    mtx_cfg_t             cfg_in;
    logic                 load, shift;
    logic                 pre_bit, data_cur, data_next;
    logic [PRE_LEN_W-1:0] pre_idx_next;
    mtx_pat_e             pat_q;

    assign cfg_in.inv = cfg_inv;
    assign cfg_in.len = cfg_pre_len;
    assign cfg_in.pat = mtx_pat_e'(cfg_pre_pat);

    mtx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .half_tick    (half_tick),
        .cfg_in       (cfg_in),
        .pre_bit      (pre_bit),
        .data_cur     (data_cur),
        .data_next    (data_next),
        .load         (load),
        .shift        (shift),
        .pre_idx_next (pre_idx_next),
        .pat_q        (pat_q),
        .line_q       (line_out),
        .busy         (busy),
        .ready        (in_ready)
    );

    mtx_pre_gen #(.IDX_W(PRE_LEN_W)) u_pre (
        .pat   (pat_q),
        .idx   (pre_idx_next),
        .bit_o (pre_bit)
    );

    mtx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .din      (in_data),
        .shift    (shift),
        .cur_bit  (data_cur),
        .next_bit (data_next)
    );

endmodule

// File: rtl/mtx_checker.sv
module mtx_checker (
    input logic clk,
    input logic rst_n,
    input logic half_tick,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic line_out
);

    // R1 / R8: line rests high whenever no frame runs
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    // R8: without a strobe the line holds its level
    a_r8_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(line_out));

    // R8: a frame ends only on a strobe
    a_r8_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(half_tick));

    // R2: accepting a word starts a frame
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R2: line still high in the cycle after accept
    a_r2_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> line_out);

endmodule

bind manchester_tx mtx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .line_out  (line_out)
);

// File: tb/manchester_tx_test.sv
module manchester_tx_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          half_tick = 1'b0;
    logic          cfg_inv = 1'b0;
    logic [3:0]    cfg_pre_len = '0;
    logic [1:0]    cfg_pre_pat = '0;
    logic          line_out;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_h [0:63];
    int   n_half;

    always #10 clk = ~clk;

    manchester_tx #(.DATA_W(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .half_tick   (half_tick),
        .cfg_inv     (cfg_inv),
        .cfg_pre_len (cfg_pre_len),
        .cfg_pre_pat (cfg_pre_pat),
        .line_out    (line_out),
        .busy        (busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one strobe, then two quiet cycles; line is compared afterwards
    task automatic do_tick();
        @(negedge clk) half_tick = 1'b1;
        @(negedge clk) half_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic pre_val(input logic [1:0] pat, input int i);
        case (pat)
            2'b00:   return 1'b1;
            2'b01:   return 1'b0;
            2'b10:   return (i % 2) == 1;
            default: return (i % 2) == 0;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 line", line_out, 1);
        check("R1 busy", busy, 0);
        check("R1 ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // send one frame and compare every half-bit
    task automatic t_frame(input string tag, input logic [DW-1:0] d, input logic inv,
                           input logic [3:0] len, input logic [1:0] pat,
                           input bit mess_cfg, input bit spam);
        logic b;
        n_half = 0;
        for (int i = 0; i < int'(len); i++) begin
            b = pre_val(pat, i) ^ inv;
            exp_h[n_half] = b; exp_h[n_half+1] = ~b; n_half += 2;
        end
        for (int i = 0; i < DW; i++) begin
            b = d[i] ^ inv;
            exp_h[n_half] = b; exp_h[n_half+1] = ~b; n_half += 2;
        end
        @(negedge clk);
        in_data = d; in_valid = 1'b1;
        cfg_inv = inv; cfg_pre_len = len; cfg_pre_pat = pat;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R2 busy after accept"}, busy, 1);
        check({tag, " R2 ready after accept"}, in_ready, 0);
        check({tag, " R2 line before tick"}, line_out, 1);
        if (mess_cfg) begin
            cfg_inv = ~inv; cfg_pre_len = len + 4'd3; cfg_pre_pat = ~pat; // R9
        end
        if (spam) begin
            in_valid = 1'b1; in_data = ~d; // R2 ignored while busy
        end
        for (int k = 0; k < n_half; k++) begin
            do_tick();
            check($sformatf("%s half %0d", tag, k), line_out, exp_h[k]);
        end
        in_valid = 1'b0;
        do_tick();
        check({tag, " R8 line high at end"}, line_out, 1);
        check({tag, " R8 busy low at end"}, busy, 0);
        check({tag, " R8 ready at end"}, in_ready, 1);
        repeat (3) @(negedge clk);
        check({tag, " R2 no frame started"}, busy, 0);
    endtask

    // quiet strobes while idle leave the line high
    task automatic t_idle_ticks();
        do_tick();
        do_tick();
        check("R8 idle ticks line", line_out, 1);
        check("R8 idle ticks busy", busy, 0);
    endtask

    initial begin
        t_reset();
        t_idle_ticks();
        t_frame("R3 R5 R6 pol0 nopre", 8'hA5, 1'b0, 4'd0, 2'b00, 1'b0, 1'b0);
        t_frame("R4 R5 pol1 nopre", 8'h3C, 1'b1, 4'd0, 2'b00, 1'b0, 1'b0);
        t_frame("R6 R7 ones len3", 8'h81, 1'b0, 4'd3, 2'b00, 1'b0, 1'b0);
        t_frame("R6 R7 zeros len1 pol1", 8'h01, 1'b1, 4'd1, 2'b01, 1'b0, 1'b0);
        t_frame("R7 zo len4", 8'hF0, 1'b0, 4'd4, 2'b10, 1'b0, 1'b0);
        t_frame("R6 R7 oz len15 pol1", 8'h6E, 1'b1, 4'd15, 2'b11, 1'b0, 1'b0);
        t_frame("R9 R2 cfg change spam", 8'h5A, 1'b0, 4'd2, 2'b10, 1'b1, 1'b1);
        t_frame("R9 oz len5 pol1 change", 8'hC3, 1'b1, 4'd5, 2'b11, 1'b1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule